// File: doc/BRIEF.md
# Designator-Selected Register Bank with Interrupt Entry

This block holds sixteen 16-bit general registers. It gives none of them a fixed role. Two 4-bit designators pick the roles at run time. P names the register that serves as program counter, and X names the register that serves as data pointer. A third 4-bit field, N, comes with each command and names the register that the command acts on. Software makes a call or a return by loading a new value into P, so nothing is pushed to memory.

The instruction decoder drives the block with one command per clock. A command can load a designator, write a register, step a register up or down by one, or fetch through the program counter, which steps R(P) up by one. When an interrupt request arrives and the interrupt-enable flag is set, the block saves only X and P, packed into the byte T. It then forces P to 1 and X to 2 and clears the enable flag. The handler uses a restore command to put X and P back from a byte laid out the same way. The values of R(P), R(X) and R(N) are always presented on the outputs for the memory-address logic and the ALU.

Top module: `dsg_regbank`

## Requirements
- R1: Command code 3 writes `wdata_i` into R(`n_i`). `rn_o` always shows R(`n_i`) combinationally, and a write shows there from the clock edge that ends the command's cycle.
- R2: Command code 1 loads P from `n_i`. `p_o` shows P, and `rp_o` shows R(P).
- R3: Command code 2 loads X from `n_i`. X keeps its value under every other command, except restore and interrupt entry. `x_o` shows X, and `rx_o` shows R(X).
- R4: While reset is asserted, P and X are 0, T is 8'h00, the interrupt-enable flag is 1 and every register is 16'h0000.
- R5: If `irq_i` is high while the enable flag is 1, `irq_taken_o` is high in that cycle. At the next edge T gets {X, P}, with X in bits 7:4 and P in bits 3:0. P becomes 1, X becomes 2 and the enable flag clears.
- R6: Any command presented in a cycle where an interrupt is taken has no effect. While the enable flag is 0, `irq_i` has no effect and the command runs normally.
- R7: Command code 10 sets the interrupt-enable flag and command code 11 clears it. `ie_o` shows the flag.
- R8: Command code 8 (fetch) increments R(P) by one. `rp_o` holds the pre-increment address during the command's cycle, and 16'hFFFF wraps to 16'h0000.
- R9: Command codes 4 and 5 increment and decrement R(`n_i`). Codes 6 and 7 increment and decrement R(X). Counts wrap modulo 2^16, so 16'h0000 decremented gives 16'hFFFF.
- R10: Command code 9 (restore) loads X from `wdata_i[7:4]` and P from `wdata_i[3:0]`.
- R11: Command code 0 and codes 12 to 15 change no register, designator, T or enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_i | input | 4 | Command code for this cycle |
| n_i | input | 4 | Register field N taken from the instruction |
| wdata_i | input | 16 | Write data; the restore byte is in bits 7:0 |
| irq_i | input | 1 | Interrupt request |
| rp_o | output | 16 | Current value of R(P) |
| rx_o | output | 16 | Current value of R(X) |
| rn_o | output | 16 | Current value of R(N) |
| p_o | output | 4 | Program-counter designator P |
| x_o | output | 4 | Data-pointer designator X |
| t_o | output | 8 | Saved designators, {X, P} |
| ie_o | output | 1 | Interrupt-enable flag |
| irq_taken_o | output | 1 | Interrupt entry happens at the coming edge |

## Verification
Every state change comes from a single register stage. A command driven in one cycle therefore shows on `p_o`, `x_o`, `t_o`, `ie_o`, `rp_o` and `rx_o` one clock edge later. The driver tags each expected item with the cycle after the one it drives, and the monitor compares the item only once the cycle counter reaches that tag. `irq_taken_o` and `rn_o` are combinational, so the bench checks them in the same cycle, shortly after it drives the inputs.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

  // Command codes presented on cmd_i by the instruction decoder.
  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_SET_P   = 4'd1,
    CMD_SET_X   = 4'd2,
    CMD_WRITE_N = 4'd3,
    CMD_INC_N   = 4'd4,
    CMD_DEC_N   = 4'd5,
    CMD_INC_X   = 4'd6,
    CMD_DEC_X   = 4'd7,
    CMD_FETCH   = 4'd8,
    CMD_RESTORE = 4'd9,
    CMD_IE_SET  = 4'd10,
    CMD_IE_CLR  = 4'd11
  } dsg_cmd_e;

  // Number of read ports on the bank: P, X, N and the modify operand.
  localparam int DSG_NRD = 4;
  localparam int RD_P    = 0;
  localparam int RD_X    = 1;
  localparam int RD_N    = 2;
  localparam int RD_MOD  = 3;

endpackage

// File: rtl/dsg_incdec.sv
module dsg_incdec #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         dec_i,
  output logic [W-1:0] y_o
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // Carry beyond W is dropped, so both directions wrap modulo 2^W.
  always_comb begin
    if (dec_i) y_o = a_i - ONE;
    else       y_o = a_i + ONE;
  end

endmodule

// File: rtl/dsg_bank.sv
module dsg_bank #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [AW-1:0]            wsel_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]   rsel_i,
  output logic [NRD-1:0][DW-1:0]   rdata_o
);

  logic [DW-1:0] regs [NREG];

  // One storage word per register, each with its own write enable.
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          hit;
    logic [DW-1:0] q;

    assign hit = we_i && (wsel_i == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wdata_i;
    end

    assign regs[i] = q;
  end

  // Independent combinational read ports.
  for (genvar j = 0; j < NRD; j++) begin : g_rd
    assign rdata_o[j] = regs[rsel_i[j]];
  end

endmodule

// File: rtl/dsg_ctrl.sv
module dsg_ctrl
  import dsg_pkg::*;
#(
  parameter int AW    = 4,
  parameter int IRQ_P = 1,
  parameter int IRQ_X = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      cmd_i,
  input  logic [AW-1:0]   n_i,
  input  logic [2*AW-1:0] byte_i,
  input  logic            irq_i,
  output logic [AW-1:0]   p_o,
  output logic [AW-1:0]   x_o,
  output logic [2*AW-1:0] t_o,
  output logic            ie_o,
  output logic            irq_taken_o,
  output logic            wr_en_o,
  output logic [AW-1:0]   wr_sel_o,
  output logic            wr_dec_o,
  output logic            wr_load_o
);

  localparam logic [AW-1:0] P_IRQ = AW'(IRQ_P);
  localparam logic [AW-1:0] X_IRQ = AW'(IRQ_X);

  logic [AW-1:0]   p_q, p_d, x_q, x_d;
  logic [2*AW-1:0] t_q, t_d;
  logic            ie_q, ie_d;
  logic            des_we, t_we, ie_we;
  logic            take;

  assign take = irq_i && ie_q;

  // Next-state logic for designators, T, enable flag and bank write controls.
  always_comb begin
    p_d       = p_q;
    x_d       = x_q;
    t_d       = t_q;
    ie_d      = ie_q;
    des_we    = 1'b0;
    t_we      = 1'b0;
    ie_we     = 1'b0;
    wr_en_o   = 1'b0;
    wr_sel_o  = n_i;
    wr_dec_o  = 1'b0;
    wr_load_o = 1'b0;
    if (take) begin
      t_d    = {x_q, p_q};
      p_d    = P_IRQ;
      x_d    = X_IRQ;
      ie_d   = 1'b0;
      des_we = 1'b1;
      t_we   = 1'b1;
      ie_we  = 1'b1;
    end else begin
      case (cmd_i)
        CMD_SET_P: begin
          p_d    = n_i;
          des_we = 1'b1;
        end
        CMD_SET_X: begin
          x_d    = n_i;
          des_we = 1'b1;
        end
        CMD_WRITE_N: begin
          wr_en_o   = 1'b1;
          wr_load_o = 1'b1;
        end
        CMD_INC_N: wr_en_o = 1'b1;
        CMD_DEC_N: begin
          wr_en_o  = 1'b1;
          wr_dec_o = 1'b1;
        end
        CMD_INC_X: begin
          wr_en_o  = 1'b1;
          wr_sel_o = x_q;
        end
        CMD_DEC_X: begin
          wr_en_o  = 1'b1;
          wr_sel_o = x_q;
          wr_dec_o = 1'b1;
        end
        CMD_FETCH: begin
          wr_en_o  = 1'b1;
          wr_sel_o = p_q;
        end
        CMD_RESTORE: begin
          x_d    = byte_i[2*AW-1:AW];
          p_d    = byte_i[AW-1:0];
          des_we = 1'b1;
        end
        CMD_IE_SET: begin
          ie_d  = 1'b1;
          ie_we = 1'b1;
        end
        CMD_IE_CLR: begin
          ie_d  = 1'b0;
          ie_we = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // State registers with explicit enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q  <= '0;
      x_q  <= '0;
      t_q  <= '0;
      ie_q <= 1'b1;
    end else begin
      if (des_we) begin
        p_q <= p_d;
        x_q <= x_d;
      end
      if (t_we)  t_q  <= t_d;
      if (ie_we) ie_q <= ie_d;
    end
  end

  assign p_o         = p_q;
  assign x_o         = x_q;
  assign t_o         = t_q;
  assign ie_o        = ie_q;
  assign irq_taken_o = take;

endmodule

// File: rtl/dsg_regbank.sv
module dsg_regbank
  import dsg_pkg::*;
#(
  parameter int  DW    = 16,
  parameter int  NREG  = 16,
  parameter int  IRQ_P = 1,
  parameter int  IRQ_X = 2,
  localparam int AW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      cmd_i,
  input  logic [AW-1:0]   n_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            irq_i,
  output logic [DW-1:0]   rp_o,
  output logic [DW-1:0]   rx_o,
  output logic [DW-1:0]   rn_o,
  output logic [AW-1:0]   p_o,
  output logic [AW-1:0]   x_o,
  output logic [2*AW-1:0] t_o,
  output logic            ie_o,
  output logic            irq_taken_o
);

  logic                        wr_en, wr_dec, wr_load;
  logic [AW-1:0]               wr_sel;
  logic [DW-1:0]               wr_data, step_val;
  logic [DSG_NRD-1:0][AW-1:0]  rsel;
  logic [DSG_NRD-1:0][DW-1:0]  rdata;

  dsg_ctrl #(
    .AW    (AW),
    .IRQ_P (IRQ_P),
    .IRQ_X (IRQ_X)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .n_i         (n_i),
    .byte_i      (wdata_i[2*AW-1:0]),
    .irq_i       (irq_i),
    .p_o         (p_o),
    .x_o         (x_o),
    .t_o         (t_o),
    .ie_o        (ie_o),
    .irq_taken_o (irq_taken_o),
    .wr_en_o     (wr_en),
    .wr_sel_o    (wr_sel),
    .wr_dec_o    (wr_dec),
    .wr_load_o   (wr_load)
  );

  assign rsel[RD_P]   = p_o;
  assign rsel[RD_X]   = x_o;
  assign rsel[RD_N]   = n_i;
  assign rsel[RD_MOD] = wr_sel;

  dsg_bank #(
    .DW   (DW),
    .NREG (NREG),
    .NRD  (DSG_NRD)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en),
    .wsel_i  (wr_sel),
    .wdata_i (wr_data),
    .rsel_i  (rsel),
    .rdata_o (rdata)
  );

  dsg_incdec #(
    .W (DW)
  ) u_step (
    .a_i   (rdata[RD_MOD]),
    .dec_i (wr_dec),
    .y_o   (step_val)
  );

  assign wr_data = wr_load ? wdata_i : step_val;

  assign rp_o = rdata[RD_P];
  assign rx_o = rdata[RD_X];
  assign rn_o = rdata[RD_N];

endmodule

// File: rtl/dsg_regbank_chk.sv
module dsg_regbank_chk
  import dsg_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int IRQ_P = 1,
  parameter int IRQ_X = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      cmd_i,
  input logic [AW-1:0]   n_i,
  input logic            irq_i,
  input logic [DW-1:0]   rp_o,
  input logic [AW-1:0]   p_o,
  input logic [AW-1:0]   x_o,
  input logic [2*AW-1:0] t_o,
  input logic            ie_o,
  input logic            irq_taken_o
);

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  // R2
  assert_set_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_SET_P && !irq_taken_o) |=> (p_o == $past(n_i)));

  // R3
  assert_x_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_taken_o && cmd_i != CMD_SET_X && cmd_i != CMD_RESTORE) |=> $stable(x_o));

  // R5
  assert_irq_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken_o |=> (p_o == AW'(IRQ_P) && x_o == AW'(IRQ_X) && !ie_o
                     && t_o == $past({x_o, p_o})));

  // R6
  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !ie_o && cmd_i == CMD_NOP) |=> ($stable(p_o) && $stable(x_o) && $stable(t_o)));

  // R7
  assert_ie_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_IE_SET && !irq_taken_o) |=> ie_o);

  // R8
  assert_fetch_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_FETCH && !irq_taken_o) |=> (rp_o == ($past(rp_o) + ONE)));

  // R11
  assert_idle_codes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == CMD_NOP || cmd_i >= 4'd12) && !irq_taken_o)
      |=> ($stable(p_o) && $stable(t_o) && $stable(ie_o) && $stable(rp_o)));

endmodule

bind dsg_regbank dsg_regbank_chk #(
  .DW    (DW),
  .AW    (AW),
  .IRQ_P (IRQ_P),
  .IRQ_X (IRQ_X)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_i       (cmd_i),
  .n_i         (n_i),
  .irq_i       (irq_i),
  .rp_o        (rp_o),
  .p_o         (p_o),
  .x_o         (x_o),
  .t_o         (t_o),
  .ie_o        (ie_o),
  .irq_taken_o (irq_taken_o)
);

// File: tb/dsg_regbank_bench.sv
`timescale 1ns/1ps
module dsg_regbank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd_i = 4'd0;
  logic [3:0]  n_i = 4'd0;
  logic [15:0] wdata_i = 16'd0;
  logic        irq_i = 1'b0;
  logic [15:0] rp_o, rx_o, rn_o;
  logic [3:0]  p_o, x_o;
  logic [7:0]  t_o;
  logic        ie_o, irq_taken_o;

  always #2.5 clk = ~clk;

  dsg_regbank u_dsg_regbank (
    .clk (clk), .rst_n (rst_n), .cmd_i (cmd_i), .n_i (n_i), .wdata_i (wdata_i),
    .irq_i (irq_i), .rp_o (rp_o), .rx_o (rx_o), .rn_o (rn_o), .p_o (p_o),
    .x_o (x_o), .t_o (t_o), .ie_o (ie_o), .irq_taken_o (irq_taken_o)
  );

  typedef struct {
    int          due;
    logic [3:0]  p, x;
    logic [7:0]  t;
    logic        ie;
    logic [15:0] rp, rx;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int   cyc = 0;
  int   nvec = 0;
  int   nbad = 0;
  bit   done = 0;

  // Reference model state
  logic [15:0] m_r [16];
  logic [3:0]  m_p, m_x;
  logic [7:0]  m_t;
  logic        m_ie;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t snap(input int due, input string req);
    exp_t e;
    e.due = due; e.p = m_p; e.x = m_x; e.t = m_t; e.ie = m_ie;
    e.rp = m_r[m_p]; e.rx = m_r[m_x]; e.req = req;
    return e;
  endfunction

  // Monitor: compares items once their due cycle is reached.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      mon_e = q.pop_front();
      nvec++;
      if (p_o !== mon_e.p || x_o !== mon_e.x || t_o !== mon_e.t || ie_o !== mon_e.ie
          || rp_o !== mon_e.rp || rx_o !== mon_e.rx) begin
        nbad++;
        $display("FAIL %s: got p=%h x=%h t=%h ie=%b rp=%h rx=%h exp p=%h x=%h t=%h ie=%b rp=%h rx=%h",
                 mon_e.req, p_o, x_o, t_o, ie_o, rp_o, rx_o,
                 mon_e.p, mon_e.x, mon_e.t, mon_e.ie, mon_e.rp, mon_e.rx);
      end
    end
  end

  task automatic step(input logic [3:0] c, input logic [3:0] n, input logic [15:0] wd,
                      input logic irq, input string req);
    logic take;
    @(negedge clk);
    cmd_i = c; n_i = n; wdata_i = wd; irq_i = irq;
    #1;
    take = irq && m_ie;
    nvec++;
    if (irq_taken_o !== take) begin
      nbad++;
      $display("FAIL R5 irq_taken (%s): got %b exp %b", req, irq_taken_o, take);
    end
    if (take) begin
      m_t = {m_x, m_p}; m_p = 4'd1; m_x = 4'd2; m_ie = 1'b0;
    end else begin
      case (c)
        4'd1:  m_p = n;
        4'd2:  m_x = n;
        4'd3:  m_r[n] = wd;
        4'd4:  m_r[n] = m_r[n] + 16'd1;
        4'd5:  m_r[n] = m_r[n] - 16'd1;
        4'd6:  m_r[m_x] = m_r[m_x] + 16'd1;
        4'd7:  m_r[m_x] = m_r[m_x] - 16'd1;
        4'd8:  m_r[m_p] = m_r[m_p] + 16'd1;
        4'd9:  begin m_x = wd[7:4]; m_p = wd[3:0]; end
        4'd10: m_ie = 1'b1;
        4'd11: m_ie = 1'b0;
        default: ;
      endcase
    end
    q.push_back(snap(cyc + 1, req));
  endtask

  task automatic peek(input logic [3:0] n, input string req);
    @(negedge clk);
    cmd_i = 4'd0; n_i = n; irq_i = 1'b0; wdata_i = 16'd0;
    #1;
    nvec++;
    if (rn_o !== m_r[n]) begin
      nbad++;
      $display("FAIL %s: R%0d read got %h exp %h", req, n, rn_o, m_r[n]);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_r[i] = 16'd0;
    m_p = 4'd0; m_x = 4'd0; m_t = 8'h00; m_ie = 1'b1;
    repeat (3) @(negedge clk);
    q.push_back(snap(cyc, "R4 reset state"));
    @(negedge clk);
    rst_n = 1'b1;
    peek(4'd0, "R4"); peek(4'd7, "R4"); peek(4'd15, "R4");

    for (int i = 0; i < 16; i++)
      step(4'd3, 4'(i), 16'h1000 + 16'(i) * 16'h0111, 1'b0, "R1 write");
    peek(4'd3, "R1"); peek(4'd12, "R1");

    step(4'd1, 4'd5, 16'h0, 1'b0, "R2 set P");
    step(4'd2, 4'd9, 16'h0, 1'b0, "R3 set X");
    step(4'd0, 4'd1, 16'h0, 1'b0, "R3 X holds");

    step(4'd8, 4'd0, 16'h0, 1'b0, "R8 fetch");
    step(4'd8, 4'd0, 16'h0, 1'b0, "R8 fetch");
    step(4'd8, 4'd0, 16'h0, 1'b0, "R8 fetch");
    step(4'd3, 4'd5, 16'hFFFF, 1'b0, "R1 write pc");
    step(4'd8, 4'd0, 16'h0, 1'b0, "R8 fetch wrap");

    step(4'd4, 4'd3, 16'h0, 1'b0, "R9 inc N");
    step(4'd5, 4'd3, 16'h0, 1'b0, "R9 dec N");
    step(4'd3, 4'd4, 16'h0000, 1'b0, "R1 write zero");
    step(4'd5, 4'd4, 16'h0, 1'b0, "R9 dec wrap");
    peek(4'd4, "R9");
    step(4'd6, 4'd0, 16'h0, 1'b0, "R9 inc X");
    step(4'd7, 4'd0, 16'h0, 1'b0, "R9 dec X");
    step(4'd7, 4'd0, 16'h0, 1'b0, "R9 dec X");

    step(4'd3, 4'd7, 16'hABCD, 1'b1, "R5 irq entry");
    peek(4'd7, "R6 dropped write");
    step(4'd1, 4'd3, 16'h0, 1'b1, "R6 masked irq");
    step(4'd0, 4'd0, 16'h0, 1'b1, "R6 masked idle");

    step(4'd9, 4'd0, 16'h0095, 1'b0, "R10 restore");
    step(4'd9, 4'd0, 16'hFF3C, 1'b0, "R10 restore");

    step(4'd10, 4'd0, 16'h0, 1'b0, "R7 ie set");
    step(4'd11, 4'd0, 16'h0, 1'b0, "R7 ie clear");
    step(4'd10, 4'd0, 16'h0, 1'b0, "R7 ie set");

    for (int c = 12; c < 16; c++)
      step(4'(c), 4'd6, 16'hFFFF, 1'b0, "R11 unused code");
    step(4'd0, 4'd6, 16'hFFFF, 1'b0, "R11 nop");
    peek(4'd6, "R11");

    step(4'd8, 4'd0, 16'h0, 1'b1, "R6 fetch dropped");
    peek(4'd12, "R6");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule